// File: doc/BRIEF.md
# Dual Lookup-Table Logic Slice

This block is one configurable logic cell built around two 16-entry truth tables. Each table is loaded as a whole 16-bit word through a synchronous configuration port. It is then read combinationally, with a 4-bit input vector used as the entry index. Three behaviours are chosen with a 2-bit mode input:

- **Dual mode:** the two tables act as independent 4-input functions.
- **Fused mode:** a fifth input steers an output multiplexer between the two tables, so the pair forms one 5-input function.
- **Read-only mode:** the tables serve as two separate 16x1 lookup stores whose contents cannot be overwritten.

Around the cell, the fabric loads each table once and then drives the input vectors. The fabric takes the per-table outputs in dual or read-only mode, and the fused output in fused mode. Changing the mode never alters the stored contents.

Top module: `dual_lut_slice`

## Requirements
- R1: Table A is read at index `in_a` and table B at index `in_b` (outside fused mode). Input bit 0 is the least significant bit of the index, and entry i is bit i of the loaded word. `out_a` and `out_b` follow the inputs combinationally.
- R2: When `cfg_we` is high at a rising clock edge and `mode` is 00 or 01, `cfg_data` replaces the whole of the table chosen by `cfg_sel` (0 = table A, 1 = table B). The other table keeps its contents.
- R3: A configuration write takes effect at the clock edge that captures it. In the cycle before that edge, the outputs still show the previous contents.
- R4: In mode 01 (fused), table B is indexed by `in_a`, and `in_b` has no effect. `out_b` is B[`in_a`], and `out_f` equals `out_a` when `in_x` is 0 and `out_b` when `in_x` is 1.
- R5: In modes 00, 10 and 11, `out_f` is 0.
- R6: In modes 10 and 11 (read-only), `cfg_we` is ignored and both tables keep their contents, while reads continue as in R1.
- R7: An active-low `rst_n` clears both tables asynchronously, so all outputs read 0 until a table is written.
- R8: Changing `mode` leaves both tables' contents untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears both tables |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Target table: 0 = A, 1 = B |
| cfg_data | input | 16 | Truth-table word, bit i is entry i |
| mode | input | 2 | 00 dual, 01 fused, 10/11 read-only |
| in_a | input | 4 | Index into table A (and into B in fused mode) |
| in_b | input | 4 | Index into table B outside fused mode |
| in_x | input | 1 | Fifth input selecting table B in fused mode |
| out_a | output | 1 | Table A result |
| out_b | output | 1 | Table B result |
| out_f | output | 1 | Fused 5-input result, 0 outside fused mode |

## Verification
Two functions can fall in the same cycle: a configuration write, and a combinational read of the very entry being rewritten. The bench provokes this by holding the write strobe and an index into the target table across one edge. It samples the output just before that edge, expecting the old entry, and again just after, expecting the new one. A second collision is a write strobe raised while the slice is in read-only mode. Here the outputs are judged unchanged after the edge, and again once the slice is switched back to a writable mode.

// File: rtl/dls_pkg.sv
package dls_pkg;

   typedef enum logic [1:0] {
      SM_DUAL    = 2'b00,
      SM_FUSED   = 2'b01,
      SM_ROM     = 2'b10,
      SM_ROM_ALT = 2'b11
   } slice_mode_e;

   localparam int unsigned TABLE_COUNT = 2;
   localparam int unsigned K_MIN = 1;
   localparam int unsigned K_MAX = 6;

   // write protection applies to both read-only encodings
   function automatic logic mode_locked(slice_mode_e m);
      return m[1];
   endfunction

   function automatic logic mode_fused(slice_mode_e m);
      return (m == SM_FUSED);
   endfunction

endpackage

// File: rtl/lut_store.sv
module lut_store #(
   parameter int unsigned K = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [(1<<K)-1:0]   wdata,
   output logic [(1<<K)-1:0]   bits
);
   localparam int unsigned DEPTH = 1 << K;

   logic [DEPTH-1:0] cells_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cells_q <= '0;
      end else if (we) begin
         cells_q <= wdata;
      end
   end

   assign bits = cells_q;

endmodule

// File: rtl/lut_read.sv
module lut_read #(
   parameter int unsigned K     = 4,
   parameter int unsigned STYLE = 0
) (
   input  logic [K-1:0]        addr,
   input  logic [(1<<K)-1:0]   bits,
   output logic                y
);
   localparam int unsigned DEPTH = 1 << K;

   generate
      if (STYLE == 0) begin : g_index
         assign y = bits[addr];
      end else begin : g_andor
         logic [DEPTH-1:0] hot;
         always_comb begin
            for (int i = 0; i < DEPTH; i++) begin
               hot[i] = (addr == K'(i));
            end
         end
         assign y = |(hot & bits);
      end
   endgenerate

endmodule

// File: rtl/slice_outmux.sv
module slice_outmux
   import dls_pkg::*;
(
   input  slice_mode_e mode,
   input  logic        in_x,
   input  logic        a_val,
   input  logic        b_val,
   output logic        f
);
   always_comb begin
      if (mode_fused(mode)) begin
         f = in_x ? b_val : a_val;
      end else begin
         f = 1'b0;
      end
   end

endmodule

// File: rtl/dual_lut_slice.sv
module dual_lut_slice
   import dls_pkg::*;
#(
   parameter int unsigned K          = 4,
   parameter int unsigned READ_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_sel,
   input  logic [(1<<K)-1:0]  cfg_data,
   input  logic [1:0]         mode,
   input  logic [K-1:0]       in_a,
   input  logic [K-1:0]       in_b,
   input  logic               in_x,
   output logic               out_a,
   output logic               out_b,
   output logic               out_f
);
   localparam int unsigned DEPTH = 1 << K;

   generate
      if (K < K_MIN || K > K_MAX) begin : g_bad_k
         $error("dual_lut_slice: K out of supported range");
      end
      if (READ_STYLE > 1) begin : g_bad_style
         $error("dual_lut_slice: READ_STYLE must be 0 or 1");
      end
   endgenerate

   slice_mode_e mode_e;
   logic        locked;
   logic        fused;

   assign mode_e = slice_mode_e'(mode);
   assign locked = mode_locked(mode_e);
   assign fused  = mode_fused(mode_e);

   logic [DEPTH-1:0] tbl_bits [TABLE_COUNT];
   logic [K-1:0]     rd_addr  [TABLE_COUNT];
   logic             rd_val   [TABLE_COUNT];

   generate
      for (genvar t = 0; t < TABLE_COUNT; t++) begin : g_tbl
         logic wr_en;
         assign wr_en = cfg_we && !locked && (cfg_sel == 1'(t));

         if (t == 0) begin : g_addr_a
            assign rd_addr[t] = in_a;
         end else begin : g_addr_b
            assign rd_addr[t] = fused ? in_a : in_b;
         end

         lut_store #(.K(K)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en),
            .wdata (cfg_data),
            .bits  (tbl_bits[t])
         );

         lut_read #(.K(K), .STYLE(READ_STYLE)) u_read (
            .addr (rd_addr[t]),
            .bits (tbl_bits[t]),
            .y    (rd_val[t])
         );
      end
   endgenerate

   assign out_a = rd_val[0];
   assign out_b = rd_val[1];

   slice_outmux u_outmux (
      .mode  (mode_e),
      .in_x  (in_x),
      .a_val (rd_val[0]),
      .b_val (rd_val[1]),
      .f     (out_f)
   );

endmodule

// File: rtl/dual_lut_slice_chk.sv
module dual_lut_slice_chk #(
   parameter int unsigned K = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cfg_we,
   input logic [1:0]   mode,
   input logic [K-1:0] in_a,
   input logic [K-1:0] in_b,
   input logic         in_x,
   input logic         out_a,
   input logic         out_b,
   input logic         out_f
);
   // R4
   fused_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && !in_x) |-> (out_f == out_a));

   // R4
   fused_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && in_x) |-> (out_f == out_b));

   // R5
   unfused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b01) |-> !out_f);

   // R6
   rom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode[1]) && $stable(mode) && $stable(in_a) && $stable(in_b))
      |-> ($stable(out_a) && $stable(out_b)));

   // R4
   fused_ignore_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(cfg_we) && mode == 2'b01 && $past(mode) == 2'b01 && $stable(in_a))
      |-> $stable(out_b));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(cfg_we) && $stable(mode) && $stable(in_a) && $stable(in_b) && $stable(in_x))
      |-> ($stable(out_a) && $stable(out_b) && $stable(out_f)));

endmodule

bind dual_lut_slice dual_lut_slice_chk #(.K(K)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cfg_we(cfg_we),
   .mode  (mode),
   .in_a  (in_a),
   .in_b  (in_b),
   .in_x  (in_x),
   .out_a (out_a),
   .out_b (out_b),
   .out_f (out_f)
);

// File: tb/tb_dual_lut_slice.sv
module tb_dual_lut_slice;
   localparam int K = 4;
   localparam int DEPTH = 1 << K;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic cfg_sel = 1'b0;
   logic [DEPTH-1:0] cfg_data = '0;
   logic [1:0] mode = 2'b00;
   logic [K-1:0] in_a = '0;
   logic [K-1:0] in_b = '0;
   logic in_x = 1'b0;
   logic out_a, out_b, out_f;

   int checks = 0;
   int errors = 0;
   logic [DEPTH-1:0] tab_a = '0;
   logic [DEPTH-1:0] tab_b = '0;

   always #10ns clk = ~clk;

   dual_lut_slice #(.K(K)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .mode(mode), .in_a(in_a), .in_b(in_b),
      .in_x(in_x), .out_a(out_a), .out_b(out_b), .out_f(out_f)
   );

   typedef struct packed {
      logic [1:0]   m;
      logic [K-1:0] a;
      logic [K-1:0] b;
      logic         x;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VECS [NVEC] = '{
      '{2'b00, 4'd0,  4'd15, 1'b0},
      '{2'b00, 4'd7,  4'd14, 1'b1},
      '{2'b00, 4'd11, 4'd15, 1'b0},
      '{2'b01, 4'd15, 4'd0,  1'b1},
      '{2'b01, 4'd15, 4'd0,  1'b0},
      '{2'b01, 4'd6,  4'd15, 1'b1},
      '{2'b01, 4'd6,  4'd15, 1'b0},
      '{2'b10, 4'd13, 4'd15, 1'b1},
      '{2'b11, 4'd3,  4'd15, 1'b0},
      '{2'b01, 4'd1,  4'd15, 1'b1}
   };

   task automatic check(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic cfg_write(logic sel, logic [DEPTH-1:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_data = data;
      @(negedge clk);
      cfg_we = 1'b0;
      if (!mode[1]) begin
         if (sel) tab_b = data; else tab_a = data;
      end
   endtask

   task automatic check_all(string req);
      logic [K-1:0] b_idx;
      logic ea, eb, ef;
      b_idx = (mode == 2'b01) ? in_a : in_b;
      ea = tab_a[in_a];
      eb = tab_b[b_idx];
      ef = (mode == 2'b01) ? (in_x ? eb : ea) : 1'b0;
      check({req, " out_a"}, out_a, ea);
      check({req, " out_b"}, out_b, eb);
      check({req, " out_f"}, out_f, ef);
   endtask

   initial begin
      #(20ns * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R7: outputs read zero while and after reset
      repeat (2) @(posedge clk);
      @(negedge clk);
      in_a = 4'd9; in_b = 4'd5; mode = 2'b01; in_x = 1'b1;
      #1;
      check("R7 in reset out_a", out_a, 1'b0);
      check("R7 in reset out_f", out_f, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 after reset out_b", out_b, 1'b0);
      mode = 2'b00;

      // R2: load parity into A, 4-input AND into B
      cfg_write(1'b0, 16'h6996);
      cfg_write(1'b1, 16'h8000);

      // vector walk: R1 dual, R4 fused, R5 zero fused output, R6 read-only reads
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         mode = VECS[i].m; in_a = VECS[i].a; in_b = VECS[i].b; in_x = VECS[i].x;
         #1;
         if (VECS[i].m == 2'b01) check_all("R4 vector");
         else if (VECS[i].m[1]) check_all("R6 R5 vector");
         else check_all("R1 R5 vector");
      end

      // R3: write and read of the same entry in one cycle
      @(negedge clk);
      mode = 2'b00; in_a = 4'd5;
      cfg_we = 1'b1; cfg_sel = 1'b0; cfg_data = 16'hFFFF;
      #1;
      check("R3 before edge", out_a, 1'b0);
      @(posedge clk);
      #1;
      check("R3 after edge", out_a, 1'b1);
      @(negedge clk);
      cfg_we = 1'b0; tab_a = 16'hFFFF;

      // R2: writing B leaves A alone
      cfg_write(1'b1, 16'h0001);
      in_a = 4'd12; in_b = 4'd0;
      #1;
      check("R2 A untouched", out_a, 1'b1);
      check("R2 B written", out_b, 1'b1);

      // R6: writes ignored in both read-only encodings
      mode = 2'b10;
      cfg_write(1'b0, 16'h0000);
      #1;
      check("R6 mode10 A kept", out_a, 1'b1);
      mode = 2'b11;
      cfg_write(1'b1, 16'hFFFE);
      #1;
      check("R6 mode11 B kept", out_b, 1'b1);

      // R8: contents survive switching back
      @(negedge clk);
      mode = 2'b00; in_a = 4'd3; in_b = 4'd0;
      #1;
      check_all("R8 after mode change");

      // R4: in_b has no effect in fused mode
      @(negedge clk);
      mode = 2'b01; in_a = 4'd2; in_b = 4'd0; in_x = 1'b1;
      #1;
      check("R4 B indexed by in_a", out_b, 1'b0);

      // R7: asynchronous clear after configuration
      @(negedge clk);
      mode = 2'b00; in_a = 4'd0; in_b = 4'd0;
      rst_n = 1'b0;
      #1;
      check("R7 async clear out_a", out_a, 1'b0);
      check("R7 async clear out_b", out_b, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      tab_a = '0; tab_b = '0;
      #1;
      check_all("R7 after second reset");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule